// File: doc/BRIEF.md
# Hash engine register front-end

This block is the register-mapped shell around an MD5 / SHA-1 compression core. Software selects the algorithm and the source of the starting chaining state in a control word, then streams message words into a single data address. The shell queues them in a 32-entry input FIFO, cuts the stream into 64-byte blocks of 16 words, and passes each block with the current chaining state to an external compression core over a request/acknowledge pair. The core's answer becomes the new chaining state.

Completion uses a self-clearing flag. Software sets the data-end bit. The bit reads as 1 until every complete block already queued has been compressed. At that point the chaining state is copied into the digest registers and the bit clears. Words that do not fill a block are thrown away at that moment, because state can only leave the engine at a block boundary. A long hash can therefore be split into several sessions. Each later session starts from the previous digest, written into the initial-value registers. Message padding is done by software.

Top module: `hash_reg_shell`

## Requirements
- R1: After reset the control word (address 0) reads 0, the status word (address 1) reads free count 32 in bits [5:0] with the overflow flag (bit 8) clear, and every digest word (addresses 9 to 13) reads 0.
- R2: A control write with bit 0 set while the engine is off enables it, latches the mode (bit 1: 0 = MD5, 1 = SHA-1) and the IV-source bit (bit 2), empties the FIFO and clears the overflow flag. The chaining state is loaded from the IV registers (addresses 4 to 8, word 0 first) when bit 2 is set. Otherwise it is loaded with the standard constants 67452301, EFCDAB89, 98BADCFE, 10325476, followed by C3D2E1F0 for SHA-1 or 0 for MD5.
- R3: Writes to address 2 while enabled go into the 32-word FIFO. Status bits [5:0] give the free entries. A write while the FIFO is full is dropped and sets the sticky overflow flag (status bit 8).
- R4: Whenever at least 16 words are queued and the engine is idle, the shell pops 16 words into a block, with the first word in bits [511:480]. It then raises the compress request and holds both the request and the block steady until acknowledge. The core's result replaces the chaining state.
- R5: Control bit 3 (data end), written as 1 while enabled, reads back 1 until no complete block is queued or in flight. Then the digest registers take the chaining state, the bit clears, and any leftover partial-block words are discarded, so the free count returns to 32.
- R6: Digest word k reads at address 9+k. In SHA-1 mode five words are valid. In MD5 mode word 4 reads 0.
- R7: A control write of 0 disables the engine at once. It drops the compress request, empties the FIFO, clears data end and makes the control word read 0. Data writes while disabled are ignored, with no change to the free count or the overflow flag.
- R8: A hash split at a 64-byte boundary gives the same digest as the unsplit hash. The second session is enabled with the IV-source bit and the first session's digest in the IV registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Word address for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| cmp_req | output | 1 | Compress request, held until acknowledge |
| cmp_sha | output | 1 | Algorithm for the core: 1 = SHA-1, 0 = MD5 |
| cmp_block | output | 512 | 16-word block, first word most significant |
| cmp_chain | output | 160 | Current chaining state, word 0 most significant |
| cmp_ack | input | 1 | One-cycle acknowledge from the core |
| cmp_result | input | 160 | New chaining state, valid with cmp_ack |

## Verification
The handshake assertions assume that the core raises cmp_ack only while cmp_req is high, for one cycle, and that software writes no data word in the cycle a data-end completion flushes the FIFO. The bench's stand-in core acknowledges a few cycles after a request, can be stalled to hold a request open, and computes a simple deterministic mix of block and chain. Software stimulus waits for data end to clear before touching the engine again, and it disables the engine before every enable, so each enable is a fresh start.

// File: rtl/hash_shell_pkg.sv
package hash_shell_pkg;
  localparam int WORD_W      = 32;
  localparam int CHAIN_WORDS = 5;
  localparam int BLK_WORDS   = 16;
  localparam int CHAIN_W     = CHAIN_WORDS * WORD_W;
  localparam int BLK_W       = BLK_WORDS * WORD_W;

  // word addresses
  localparam int A_CTRL = 0;
  localparam int A_STAT = 1;
  localparam int A_DATA = 2;
  localparam int A_IV0  = 4;
  localparam int A_DIG0 = 9;

  // control bit positions
  localparam int C_EN  = 0;
  localparam int C_SHA = 1;
  localparam int C_IV  = 2;
  localparam int C_END = 3;
  localparam int S_OVF = 8;

  typedef enum logic [1:0] {SQ_IDLE, SQ_FILL, SQ_WAIT} seq_state_e;

  // standard starting state; fifth word only meaningful for SHA-1
  function automatic logic [CHAIN_W-1:0] std_chain(input logic sha);
    logic [CHAIN_W-1:0] c;
    c = {32'h6745_2301, 32'hEFCD_AB89, 32'h98BA_DCFE, 32'h1032_5476, 32'h0};
    if (sha) c[WORD_W-1:0] = 32'hC3D2_E1F0;
    return c;
  endfunction

  // free entries of a queue of the given depth
  function automatic int unsigned free_slots(input int unsigned depth,
                                             input int unsigned used);
    return depth - used;
  endfunction
endpackage

// File: rtl/hash_in_fifo.sv
module hash_in_fifo #(
  parameter int DEPTH = 32,
  parameter int W     = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic [CW-1:0] count,
  output logic          full
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          push_ok, pop_ok;

  assign full    = (count == CW'(DEPTH));
  assign push_ok = push && !full;
  assign pop_ok  = pop && (count != '0);
  assign rdata   = mem[rp];

  always_ff @(posedge clk) begin
    if (push_ok && !flush) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push_ok) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (pop_ok)  rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
      count <= count + CW'(push_ok) - CW'(pop_ok);
    end
  end

  // R3: occupancy never exceeds the depth
  a_r3_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  // R3: a write into a full queue leaves the occupancy unchanged
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop && !flush) |=> (count == $past(count)));
endmodule

// File: rtl/hash_block_seq.sv
module hash_block_seq #(
  parameter int CW        = 6,
  parameter int BLK_WORDS = 16,
  parameter int W         = 32,
  localparam int BW       = BLK_WORDS * W,
  localparam int NW       = $clog2(BLK_WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go_ok,
  input  logic          abort,
  input  logic [CW-1:0] fifo_count,
  input  logic [W-1:0]  fifo_rdata,
  output logic          fifo_pop,
  output logic [BW-1:0] block,
  output logic          cmp_req,
  input  logic          cmp_ack,
  output logic          busy,
  output logic          blk_done
);
  import hash_shell_pkg::*;

  seq_state_e    st;
  logic [NW-1:0] n;
  logic          start;

  assign start    = (st == SQ_IDLE) && go_ok && !abort &&
                    (fifo_count >= CW'(BLK_WORDS));
  assign fifo_pop = (st == SQ_FILL) && !abort;
  assign cmp_req  = (st == SQ_WAIT);
  assign blk_done = (st == SQ_WAIT) && cmp_ack && !abort;
  assign busy     = (st != SQ_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= SQ_IDLE;
      n     <= '0;
      block <= '0;
    end else if (abort) begin
      st <= SQ_IDLE;
      n  <= '0;
    end else begin
      case (st)
        SQ_IDLE: if (start) begin
          st <= SQ_FILL;
          n  <= '0;
        end
        SQ_FILL: begin
          block <= {block[BW-W-1:0], fifo_rdata};
          n     <= n + 1'b1;
          if (n == NW'(BLK_WORDS-1)) st <= SQ_WAIT;
        end
        SQ_WAIT: if (cmp_ack) st <= SQ_IDLE;
        default: st <= SQ_IDLE;
      endcase
    end
  end

  // R4: request stays up until acknowledged
  a_r4_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_req && !cmp_ack && !abort) |=> cmp_req);
  // R4: block stays steady while the request is open
  a_r4_block_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_req && !cmp_ack && !abort) |=> $stable(block));
  // R4: a pop always finds a word in the queue
  a_r4_pop_has_data: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> (fifo_count != '0));
endmodule

// File: rtl/hash_reg_shell.sv
module hash_reg_shell
  import hash_shell_pkg::*;
#(
  parameter int FIFO_DEPTH = 32,
  parameter int ADDR_W     = 4,
  localparam int CNT_W     = $clog2(FIFO_DEPTH) + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic               cmp_req,
  output logic               cmp_sha,
  output logic [BLK_W-1:0]   cmp_block,
  output logic [CHAIN_W-1:0] cmp_chain,
  input  logic               cmp_ack,
  input  logic [CHAIN_W-1:0] cmp_result
);
  logic               en_q, sha_q, ivsel_q, end_q, ovf_q, dig_sha_q;
  logic [31:0]        iv_q [CHAIN_WORDS];
  logic [CHAIN_W-1:0] iv_flat, chain_q, dig_q;
  logic [CNT_W-1:0]   fifo_cnt, free_cnt;
  logic [31:0]        fifo_rdata;
  logic               fifo_full, fifo_pop, fifo_flush, data_push;
  logic               seq_busy, blk_done;

  // named events
  logic ctl_wr, start_en, stop_en, end_set, end_done;

  assign ctl_wr    = reg_we && (reg_addr == ADDR_W'(A_CTRL));
  assign start_en  = ctl_wr && reg_wdata[C_EN] && !en_q;
  assign stop_en   = ctl_wr && !reg_wdata[C_EN];
  assign end_set   = ctl_wr && reg_wdata[C_END] && (en_q || start_en);
  assign end_done  = end_q && en_q && !stop_en && !seq_busy &&
                     (fifo_cnt < CNT_W'(BLK_WORDS));
  assign data_push = reg_we && (reg_addr == ADDR_W'(A_DATA)) && en_q;
  assign fifo_flush = start_en || stop_en || end_done;
  assign free_cnt  = CNT_W'(free_slots(FIFO_DEPTH, int'(fifo_cnt)));

  for (genvar k = 0; k < CHAIN_WORDS; k++) begin : g_iv
    assign iv_flat[CHAIN_W-1-32*k -: 32] = iv_q[k];
    always_ff @(posedge clk) begin
      if (!rst_n) iv_q[k] <= '0;
      else if (reg_we && reg_addr == ADDR_W'(A_IV0 + k)) iv_q[k] <= reg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || stop_en) begin
      en_q    <= 1'b0;
      sha_q   <= 1'b0;
      ivsel_q <= 1'b0;
      end_q   <= 1'b0;
    end else if (start_en) begin
      en_q    <= 1'b1;
      sha_q   <= reg_wdata[C_SHA];
      ivsel_q <= reg_wdata[C_IV];
      end_q   <= reg_wdata[C_END];
    end else if (end_done) begin
      end_q <= 1'b0;
    end else if (end_set) begin
      end_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain_q   <= '0;
      dig_q     <= '0;
      dig_sha_q <= 1'b0;
      ovf_q     <= 1'b0;
    end else begin
      if (start_en)
        chain_q <= reg_wdata[C_IV] ? iv_flat : std_chain(reg_wdata[C_SHA]);
      else if (blk_done)
        chain_q <= cmp_result;
      if (end_done) begin
        dig_q     <= chain_q;
        dig_sha_q <= sha_q;
      end
      if (start_en) ovf_q <= 1'b0;
      else if (data_push && fifo_full) ovf_q <= 1'b1;
    end
  end

  hash_in_fifo #(.DEPTH(FIFO_DEPTH), .W(32)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(fifo_flush), .push(data_push),
    .wdata(reg_wdata), .pop(fifo_pop), .rdata(fifo_rdata),
    .count(fifo_cnt), .full(fifo_full)
  );

  hash_block_seq #(.CW(CNT_W), .BLK_WORDS(BLK_WORDS), .W(32)) u_seq (
    .clk(clk), .rst_n(rst_n), .go_ok(en_q), .abort(stop_en),
    .fifo_count(fifo_cnt), .fifo_rdata(fifo_rdata), .fifo_pop(fifo_pop),
    .block(cmp_block), .cmp_req(cmp_req), .cmp_ack(cmp_ack),
    .busy(seq_busy), .blk_done(blk_done)
  );

  assign cmp_sha   = sha_q;
  assign cmp_chain = chain_q;

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(A_CTRL)) begin
      reg_rdata[C_EN]  = en_q;
      reg_rdata[C_SHA] = sha_q;
      reg_rdata[C_IV]  = ivsel_q;
      reg_rdata[C_END] = end_q;
    end
    if (reg_addr == ADDR_W'(A_STAT)) begin
      reg_rdata[CNT_W-1:0] = free_cnt;
      reg_rdata[S_OVF]     = ovf_q;
    end
    for (int k = 0; k < CHAIN_WORDS; k++) begin
      if (reg_addr == ADDR_W'(A_IV0 + k)) reg_rdata = iv_q[k];
      if (reg_addr == ADDR_W'(A_DIG0 + k))
        reg_rdata = (k == CHAIN_WORDS-1 && !dig_sha_q) ? 32'h0
                                                      : dig_q[CHAIN_W-1-32*k -: 32];
    end
  end

  // R2: a fresh enable starts with an empty queue and no overflow
  a_r2_enable_empty: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_q) |-> (fifo_cnt == '0 && !ovf_q));
  // R5: completion leaves nothing queued and no request open
  a_r5_done_clean: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(end_q) && en_q) |-> (fifo_cnt == '0 && !cmp_req));
  // R7: a disabled engine never requests compression
  a_r7_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !cmp_req);
endmodule

// File: tb/sim_hash_reg_shell.sv
module sim_hash_reg_shell;
  logic         clk = 0;
  logic         rst_n = 0;
  logic         reg_we = 0;
  logic [3:0]   reg_addr = 0;
  logic [31:0]  reg_wdata = 0;
  logic [31:0]  reg_rdata;
  logic         cmp_req, cmp_sha, cmp_ack;
  logic [511:0] cmp_block;
  logic [159:0] cmp_chain, cmp_result;
  logic         stall = 0;
  logic [2:0]   dly;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;  // 250 MHz

  hash_reg_shell u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmp_req(cmp_req),
    .cmp_sha(cmp_sha), .cmp_block(cmp_block), .cmp_chain(cmp_chain),
    .cmp_ack(cmp_ack), .cmp_result(cmp_result)
  );

  // stand-in compression function
  function automatic logic [159:0] mix(input logic [159:0] ch, input logic [511:0] b);
    logic [31:0] s = 0;
    logic [159:0] o;
    for (int i = 0; i < 16; i++) s = s + b[511-32*i -: 32];
    for (int k = 0; k < 5; k++)
      o[159-32*k -: 32] = (ch[159-32*k -: 32] ^ 32'(k+1)) + s;
    return o;
  endfunction

  function automatic logic [31:0] wgen(input int seed, input int i);
    return (32'(seed) * 32'h9E37_79B1) ^ (32'(i) * 32'h0101_0107) ^ 32'(i);
  endfunction

  function automatic logic [511:0] blk(input int seed);
    logic [511:0] b;
    for (int i = 0; i < 16; i++) b[511-32*i -: 32] = wgen(seed, i);
    return b;
  endfunction

  localparam logic [159:0] STD_SHA = {32'h67452301, 32'hEFCDAB89, 32'h98BADCFE,
                                      32'h10325476, 32'hC3D2E1F0};
  localparam logic [159:0] STD_MD5 = {32'h67452301, 32'hEFCDAB89, 32'h98BADCFE,
                                      32'h10325476, 32'h0};

  always @(posedge clk) begin
    if (!rst_n) begin
      cmp_ack <= 0; dly <= 0; cmp_result <= '0;
    end else if (cmp_ack) begin
      cmp_ack <= 0;
    end else if (cmp_req && !stall) begin
      if (dly == 3'd2) begin
        cmp_ack <= 1; dly <= 0; cmp_result <= mix(cmp_chain, cmp_block);
      end else dly <= dly + 1;
    end else dly <= 0;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = 4'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = 4'(a);
    #1 d = reg_rdata;
  endtask

  task automatic enable(input logic [31:0] c);
    wr(0, 0);
    wr(0, c);
  endtask

  task automatic push_blk(input int seed, input int nwords);
    for (int i = 0; i < nwords; i++) wr(2, wgen(seed, i));
  endtask

  task automatic finish_hash(input string tag);
    logic [31:0] v;
    bit ok = 0;
    wr(0, 32'h0000_0008 | 32'h1);
    for (int t = 0; t < 400 && !ok; t++) begin
      rd(0, v);
      if (v[3] == 0) ok = 1;
    end
    chk({tag, " data-end cleared"}, 32'(ok), 1);
  endtask

  task automatic chk_digest(input string tag, input logic [159:0] exp, input int nw);
    logic [31:0] v;
    for (int k = 0; k < 5; k++) begin
      rd(9 + k, v);
      chk(tag, v, (k < nw) ? exp[159-32*k -: 32] : 32'h0);
    end
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(0, v); chk("R1 ctrl", v, 0);
    rd(1, v); chk("R1 status", v, 32'h20);
    rd(9, v); chk("R1 digest0", v, 0);
  endtask

  task automatic t_std_iv;
    enable(32'h3);            // SHA-1, standard start
    finish_hash("R2");
    chk_digest("R2 R6 sha std", STD_SHA, 5);
    enable(32'h1);            // MD5
    finish_hash("R2");
    chk_digest("R2 R6 md5 std", STD_MD5, 4);
  endtask

  task automatic t_arb_iv;
    logic [159:0] iv = {32'h11111111, 32'h22222222, 32'h33333333, 32'h44444444, 32'h55555555};
    for (int k = 0; k < 5; k++) wr(4 + k, iv[159-32*k -: 32]);
    enable(32'h7);
    finish_hash("R2");
    chk_digest("R2 arbitrary iv", iv, 5);
  endtask

  task automatic t_one_block;
    logic [31:0] v;
    stall = 1;
    enable(32'h3);
    push_blk(7, 16);
    repeat (30) @(negedge clk);
    chk("R4 req raised", 32'(cmp_req), 1);
    chk("R4 block word0 top", cmp_block[511:480], wgen(7, 0));
    chk("R4 chain shown", cmp_chain[159:128], 32'h67452301);
    wr(0, 32'h9);
    rd(0, v); chk("R5 data-end pending", 32'(v[3]), 1);
    stall = 0;
    finish_hash("R5");
    chk_digest("R4 one block", mix(STD_SHA, blk(7)), 5);
  endtask

  task automatic t_overflow;
    logic [31:0] v;
    stall = 1;
    enable(32'h3);
    push_blk(1, 16);
    repeat (30) @(negedge clk);
    push_blk(2, 16);
    push_blk(3, 16);
    rd(1, v); chk("R3 full", v, 32'h0);
    wr(2, 32'hDEAD_BEEF);
    rd(1, v); chk("R3 overflow sticky", v, 32'h100);
    stall = 0;
    finish_hash("R3");
    chk_digest("R3 dropped word", mix(mix(mix(STD_SHA, blk(1)), blk(2)), blk(3)), 5);
    enable(32'h3);
    rd(1, v); chk("R2 overflow cleared", v, 32'h20);
  endtask

  task automatic t_partial;
    logic [31:0] v;
    enable(32'h1);
    push_blk(9, 16);
    push_blk(10, 4);
    finish_hash("R5");
    chk_digest("R5 R6 partial discarded", mix(STD_MD5, blk(9)), 4);
    rd(1, v); chk("R5 free back to 32", v, 32'h20);
  endtask

  task automatic t_disable;
    logic [31:0] v;
    stall = 1;
    enable(32'h3);
    push_blk(4, 16);
    repeat (30) @(negedge clk);
    wr(0, 32'h0);
    chk("R7 req dropped", 32'(cmp_req), 0);
    rd(0, v); chk("R7 ctrl zero", v, 0);
    wr(2, 32'h1234_5678);
    rd(1, v); chk("R7 write ignored", v, 32'h20);
    stall = 0;
  endtask

  task automatic t_resume;
    logic [159:0] da, db;
    logic [31:0] v;
    enable(32'h3);
    push_blk(21, 16); push_blk(22, 16);
    finish_hash("R8");
    for (int k = 0; k < 5; k++) begin rd(9 + k, v); da[159-32*k -: 32] = v; end
    enable(32'h3);
    push_blk(21, 16);
    finish_hash("R8");
    for (int k = 0; k < 5; k++) begin rd(9 + k, v); wr(4 + k, v); end
    enable(32'h7);
    push_blk(22, 16);
    finish_hash("R8");
    for (int k = 0; k < 5; k++) begin rd(9 + k, v); db[159-32*k -: 32] = v; end
    for (int k = 0; k < 5; k++)
      chk("R8 split equals whole", db[159-32*k -: 32], da[159-32*k -: 32]);
    chk("R8 expected", db[159:128], mix(mix(STD_SHA, blk(21)), blk(22)) >> 128);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_std_iv();
    t_arb_iv();
    t_one_block();
    t_overflow();
    t_partial();
    t_disable();
    t_resume();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule